// File: doc/BRIEF.md
# Touch ADC Conversion Sequencer

This block is the control state machine of a touch-screen measurement front end. A 16-bit configuration word carries an 8-bit channel-enable mask in its low byte and alert-suppression bits in its high byte. A 2-bit mode input selects one of four behaviours: idle, a single sequence, timed repetition, or repetition gated by a touch-detect input. For every enabled channel the sequencer drives the channel select, waits a programmable acquisition time, and then issues a one-cycle conversion request to an external ADC. It waits for the ADC's done strobe. When filtering is on, it collects a fixed number of samples per channel, hands them to an external filter stage and waits for its result. Each final value is written out on a result-write port.

Values from the three auxiliary channels are compared against per-channel low/high limits. An out-of-range value sets a sticky alert flag and raises the interrupt output, unless that channel's suppression bit is set. Forcing the mode to idle abandons any sequence in progress. A mode written while a sequence is running takes effect when that sequence ends.

States: S_IDLE (no activity), S_TOUCH_WAIT (wait for first touch), S_NEXT (pick the next enabled channel), S_ACQ (acquisition wait), S_REQ (conversion request), S_WAIT_CONV (wait for ADC), S_FILT_GO (start filter), S_FILT_WAIT (wait for filter), S_WRITE (result write and limit check), S_SEQ_END (load timer), S_TIMER (wait for timer expiry).

Transitions:
- S_IDLE goes to S_NEXT when the mode changes to single or slave. It goes to S_TOUCH_WAIT when the mode is master.
- S_TOUCH_WAIT goes to S_NEXT on touch.
- S_NEXT goes to S_ACQ if an enabled channel remains, and to S_SEQ_END otherwise.
- S_ACQ goes to S_REQ once the acquisition count is reached. S_REQ goes to S_WAIT_CONV.
- S_WAIT_CONV, on the done strobe, goes to S_WRITE when filtering is off. With filtering on it goes back to S_REQ for further samples, or to S_FILT_GO after the last one.
- S_FILT_GO goes to S_FILT_WAIT, which goes to S_WRITE on the filter's done strobe.
- S_WRITE goes to S_NEXT.
- S_SEQ_END goes to S_TIMER in master mode, and in slave mode with a non-zero interval. Otherwise it goes to S_IDLE.
- S_TIMER, on expiry, goes to S_NEXT in slave mode. In master mode it goes to S_NEXT if the screen is touched and to S_TOUCH_WAIT if not.
- From any state, mode 00 forces S_IDLE on the next clock.

Top module: `touch_seq_ctrl`

## Requirements
- R1: After reset conv_req, wr_en, acq_active, filt_go, irq and alert_flags are all 0.
- R2: Channels are identified by their mask bit position: 7 X+, 6 Y+, 5 Z1, 4 Z2, 3 AUX, 2 VBAT, 1 TEMP. A sequence converts the enabled channels from the highest bit down and skips disabled ones. Bit 0 never causes a conversion, and every conv_req and wr_en carries an enabled channel.
- R3: Mode 00 performs no conversions. Changing the mode to 01 runs exactly one sequence, after which the block stays idle.
- R4: Mode 10 runs a sequence and loads the timer. With interval 00 it does not repeat. With intervals 01, 10 and 11 it repeats after 2, 4 and 8 timer ticks, where one tick is 4 clocks.
- R5: Mode 11 converts nothing until touch is 1. It repeats after each timer expiry while touch is 1, and stops once touch is 0 at expiry.
- R6: For each channel acq_active is high for exactly acq_cycles+1 clocks, and then conv_req is pulsed for one cycle.
- R7: With filt_en=1 each channel is converted 4 times. Each result is presented with filt_push, then filt_go is pulsed, and filt_result is written. With filt_en=0 the single conv_data is written.
- R8: A result outside its limits sets the matching alert_flags bit and raises irq: TEMP (channel 1) sets bit 0, VBAT (channel 2) bit 1, AUX (channel 3) bit 2. The limits sit at lim_lo/lim_hi bits [11:0] for TEMP, [23:12] for VBAT and [35:24] for AUX. An alert bit can only rise in the cycle after a result write.
- R9: cfg_word bits 9, 10 and 11 suppress the alert for TEMP, VBAT and AUX respectively.
- R10: Mode 00 forces idle on the next clock, with no further request, write or filter start. A later sequence starts again from the highest enabled channel.
- R11: alert_clr clears all alert flags and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 16 | [15:8] alert suppression, [7:0] channel-enable mask |
| mode | input | 2 | 00 idle, 01 single, 10 slave, 11 master |
| interval | input | 2 | Timer interval select |
| acq_cycles | input | 4 | Acquisition wait setting |
| filt_en | input | 1 | Enable multi-sample filtering |
| touch | input | 1 | Screen touched |
| lim_lo | input | 36 | Low limits for TEMP, VBAT, AUX |
| lim_hi | input | 36 | High limits for TEMP, VBAT, AUX |
| alert_clr | input | 1 | Clear alert flags |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Selected channel |
| conv_done | input | 1 | ADC result valid |
| conv_data | input | 12 | ADC result |
| acq_active | output | 1 | Acquisition wait in progress |
| filt_push | output | 1 | conv_data is a sample for the filter |
| filt_go | output | 1 | Start filter evaluation |
| filt_done | input | 1 | Filter result valid |
| filt_result | input | 12 | Filtered value |
| wr_en | output | 1 | Result write strobe |
| wr_chan | output | 3 | Channel of written result |
| wr_data | output | 12 | Written result |
| alert_flags | output | 3 | Sticky alert flags |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after three kinds of corner case: masks with sparse bits, masks with only bit 0 set, and masks that mix bit 0 with a high bit. A design that scanned in the wrong direction or honoured bit 0 would emit writes in the wrong order or for a phantom channel. The acquisition wait is measured at both ends of its range, 0 and 15. An off-by-one counter would show one clock too many or too few. A mid-acquisition abort followed by a restart exposes a design that keeps its channel pointer or partial filter state. Touch release in master mode and interval 00 in slave mode expose repetition logic that fails to stop. One run sets a suppression bit beside an unsuppressed violation, which catches a design that maps suppression to the wrong channel.

// File: rtl/touch_seq_pkg.sv
package touch_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TOUCH_WAIT,
        S_NEXT,
        S_ACQ,
        S_REQ,
        S_WAIT_CONV,
        S_FILT_GO,
        S_FILT_WAIT,
        S_WRITE,
        S_SEQ_END,
        S_TIMER
    } seq_state_t;

    localparam logic [1:0] MODE_OFF    = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;
    localparam logic [1:0] MODE_SLAVE  = 2'b10;
    localparam logic [1:0] MODE_MASTER = 2'b11;

    localparam int N_LIM_CH = 3;

endpackage

// File: rtl/tsq_chan_pick.sv
module tsq_chan_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH),
    localparam int CW = IW + 1
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  below,
    output logic           found,
    output logic [IW-1:0]  idx
);

    logic unused_mask_bit;
    assign unused_mask_bit = mask[0];

    // Ascending scan: the last hit below the pointer is the highest one.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = 1; b < NCH; b++) begin
            if (mask[b] && (CW'(b) < below)) begin
                found = 1'b1;
                idx   = IW'(b);
            end
        end
    end

endmodule

// File: rtl/tsq_timer.sv
module tsq_timer #(
    parameter int PRESC = 4,
    parameter int T1    = 2,
    parameter int T2    = 4,
    parameter int T3    = 8,
    localparam int TW   = $clog2(T3 + 1),
    localparam int PW   = $clog2(PRESC)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       busy
);

    logic [TW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic [TW-1:0] reload;

    always_comb begin
        unique case (sel)
            2'b01:   reload = TW'(T1);
            2'b10:   reload = TW'(T2);
            2'b11:   reload = TW'(T3);
            default: reload = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (load) begin
            cnt  <= reload;
            pcnt <= '0;
        end else if (cnt != '0) begin
            if (pcnt == PW'(PRESC - 1)) begin
                pcnt <= '0;
                cnt  <= cnt - 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/tsq_limit_chk.sv
module tsq_limit_chk #(
    parameter int DW  = 12,
    parameter int IW  = 3,
    localparam int NL = touch_seq_pkg::N_LIM_CH
) (
    input  logic [IW-1:0]    chan,
    input  logic [DW-1:0]    data,
    input  logic [NL*DW-1:0] lim_lo,
    input  logic [NL*DW-1:0] lim_hi,
    input  logic [NL-1:0]    suppress,
    output logic [NL-1:0]    hit
);

    for (genvar k = 0; k < NL; k++) begin : g_lim
        localparam logic [IW-1:0] CH = IW'(k + 1);
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        assign lo     = lim_lo[k*DW +: DW];
        assign hi     = lim_hi[k*DW +: DW];
        assign hit[k] = (chan == CH) && !suppress[k] && ((data < lo) || (data > hi));
    end

endmodule

// File: rtl/touch_seq_ctrl.sv
module touch_seq_ctrl
    import touch_seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DW     = 12,
    parameter int N_SAMP = 4,
    parameter int PRESC  = 4,
    parameter int T1     = 2,
    parameter int T2     = 4,
    parameter int T3     = 8,
    localparam int IW    = $clog2(NCH),
    localparam int CW    = IW + 1,
    localparam int SW    = (N_SAMP > 1) ? $clog2(N_SAMP) : 1,
    localparam int NL    = N_LIM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      cfg_word,
    input  logic [1:0]       mode,
    input  logic [1:0]       interval,
    input  logic [3:0]       acq_cycles,
    input  logic             filt_en,
    input  logic             touch,
    input  logic [NL*DW-1:0] lim_lo,
    input  logic [NL*DW-1:0] lim_hi,
    input  logic             alert_clr,
    output logic             conv_req,
    output logic [IW-1:0]    conv_chan,
    input  logic             conv_done,
    input  logic [DW-1:0]    conv_data,
    output logic             acq_active,
    output logic             filt_push,
    output logic             filt_go,
    input  logic             filt_done,
    input  logic [DW-1:0]    filt_result,
    output logic             wr_en,
    output logic [IW-1:0]    wr_chan,
    output logic [DW-1:0]    wr_data,
    output logic [NL-1:0]    alert_flags,
    output logic             irq
);

    seq_state_t    state, nxt;
    logic [CW-1:0] cur;
    logic [3:0]    acq_cnt;
    logic [SW-1:0] samp_cnt;
    logic [DW-1:0] result;
    logic [NL-1:0] alert;
    logic [1:0]    mode_q;

    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          tmr_busy;
    logic [NL-1:0] lim_hit;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_word[15:12], cfg_word[8]};

    tsq_chan_pick #(.NCH(NCH)) u_pick (
        .mask  (cfg_word[NCH-1:0]),
        .below (cur),
        .found (pick_found),
        .idx   (pick_idx)
    );

    tsq_timer #(.PRESC(PRESC), .T1(T1), .T2(T2), .T3(T3)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == S_SEQ_END),
        .sel   (interval),
        .busy  (tmr_busy)
    );

    tsq_limit_chk #(.DW(DW), .IW(IW)) u_lim (
        .chan     (cur[IW-1:0]),
        .data     (result),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .suppress (cfg_word[11:9]),
        .hit      (lim_hit)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (mode == MODE_MASTER)
                    nxt = S_TOUCH_WAIT;
                else if ((mode != mode_q) && ((mode == MODE_SINGLE) || (mode == MODE_SLAVE)))
                    nxt = S_NEXT;
            end
            S_TOUCH_WAIT: if (touch) nxt = S_NEXT;
            S_NEXT:       nxt = pick_found ? S_ACQ : S_SEQ_END;
            S_ACQ:        if (acq_cnt == acq_cycles) nxt = S_REQ;
            S_REQ:        nxt = S_WAIT_CONV;
            S_WAIT_CONV: begin
                if (conv_done) begin
                    if (!filt_en)
                        nxt = S_WRITE;
                    else if (samp_cnt == SW'(N_SAMP - 1))
                        nxt = S_FILT_GO;
                    else
                        nxt = S_REQ;
                end
            end
            S_FILT_GO:    nxt = S_FILT_WAIT;
            S_FILT_WAIT:  if (filt_done) nxt = S_WRITE;
            S_WRITE:      nxt = S_NEXT;
            S_SEQ_END: begin
                if ((mode == MODE_MASTER) || ((mode == MODE_SLAVE) && (interval != 2'b00)))
                    nxt = S_TIMER;
                else
                    nxt = S_IDLE;
            end
            S_TIMER: begin
                if (!tmr_busy) begin
                    if (mode == MODE_SLAVE)
                        nxt = S_NEXT;
                    else if (mode == MODE_MASTER)
                        nxt = touch ? S_NEXT : S_TOUCH_WAIT;
                    else
                        nxt = S_IDLE;
                end
            end
            default:      nxt = S_IDLE;
        endcase
        if (mode == MODE_OFF)
            nxt = S_IDLE;
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur      <= CW'(NCH);
            acq_cnt  <= '0;
            samp_cnt <= '0;
            result   <= '0;
            alert    <= '0;
            mode_q   <= MODE_OFF;
        end else begin
            state  <= nxt;
            mode_q <= mode;

            if ((state == S_IDLE) || (state == S_TOUCH_WAIT) ||
                (state == S_SEQ_END) || (state == S_TIMER))
                cur <= CW'(NCH);
            else if ((state == S_NEXT) && pick_found)
                cur <= {1'b0, pick_idx};

            acq_cnt <= (state == S_ACQ) ? acq_cnt + 1'b1 : 4'd0;

            if (state == S_NEXT)
                samp_cnt <= '0;
            else if ((state == S_WAIT_CONV) && conv_done)
                samp_cnt <= samp_cnt + 1'b1;

            if ((state == S_WAIT_CONV) && conv_done)
                result <= conv_data;
            else if ((state == S_FILT_WAIT) && filt_done)
                result <= filt_result;

            if (alert_clr)
                alert <= '0;
            else if (state == S_WRITE)
                alert <= alert | lim_hit;
        end
    end

    // Outputs decoded from state
    always_comb begin
        conv_req    = (state == S_REQ);
        acq_active  = (state == S_ACQ);
        conv_chan   = cur[IW-1:0];
        filt_push   = (state == S_WAIT_CONV) && conv_done && filt_en;
        filt_go     = (state == S_FILT_GO);
        wr_en       = (state == S_WRITE);
        wr_chan     = cur[IW-1:0];
        wr_data     = result;
        alert_flags = alert;
        irq         = |alert;
    end

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
    parameter int IW = 3,
    parameter int NL = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   cfg_word,
    input logic [1:0]    mode,
    input logic          filt_en,
    input logic          conv_req,
    input logic [IW-1:0] conv_chan,
    input logic          conv_done,
    input logic          acq_active,
    input logic          filt_go,
    input logic          wr_en,
    input logic [IW-1:0] wr_chan,
    input logic [NL-1:0] alert_flags
);

    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    p_req_after_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req) |-> ($past(acq_active) || $past(conv_done)));

    p_req_chan_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> ((conv_chan != '0) && cfg_word[conv_chan]));

    p_wr_chan_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_chan != '0) && cfg_word[wr_chan]));

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (!conv_req && !wr_en && !acq_active && !filt_go));

    p_alert_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((alert_flags & ~$past(alert_flags)) == '0));

    p_filt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        filt_go |-> filt_en);

endmodule

bind touch_seq_ctrl tsq_checker #(.IW(IW), .NL(NL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_word    (cfg_word),
    .mode        (mode),
    .filt_en     (filt_en),
    .conv_req    (conv_req),
    .conv_chan   (conv_chan),
    .conv_done   (conv_done),
    .acq_active  (acq_active),
    .filt_go     (filt_go),
    .wr_en       (wr_en),
    .wr_chan     (wr_chan),
    .alert_flags (alert_flags)
);

// File: tb/touch_seq_ctrl_bench.sv
`timescale 1ns/1ps
module touch_seq_ctrl_bench;

    localparam int NSAMP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  interval = 2'b00;
    logic [3:0]  acq_cycles = '0;
    logic        filt_en = 1'b0;
    logic        touch = 1'b0;
    logic [35:0] lim_lo = '0;
    logic [35:0] lim_hi = {3{12'hFFF}};
    logic        alert_clr = 1'b0;
    logic        conv_req;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        acq_active;
    logic        filt_push;
    logic        filt_go;
    logic        filt_done = 1'b0;
    logic [11:0] filt_result = '0;
    logic        wr_en;
    logic [2:0]  wr_chan;
    logic [11:0] wr_data;
    logic [2:0]  alert_flags;
    logic        irq;

    touch_seq_ctrl u_touch_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .mode(mode),
        .interval(interval), .acq_cycles(acq_cycles), .filt_en(filt_en),
        .touch(touch), .lim_lo(lim_lo), .lim_hi(lim_hi), .alert_clr(alert_clr),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .acq_active(acq_active), .filt_push(filt_push),
        .filt_go(filt_go), .filt_done(filt_done), .filt_result(filt_result),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .alert_flags(alert_flags), .irq(irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ADC model: answers a request two falling edges later; value = chan*256 + 2*k
    int         adc_cnt = 0;
    int         adc_k = 0;
    logic [2:0] adc_ch = '0;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (wr_en) adc_k = 0;
        if (adc_cnt == 1) begin
            conv_done = 1'b1;
            conv_data = 12'(int'(adc_ch) * 256 + adc_k * 2);
            adc_k++;
        end
        if (adc_cnt > 0) adc_cnt--;
        if (conv_req) begin
            adc_cnt = 2;
            adc_ch  = conv_chan;
        end
        if (mode == 2'b00) begin
            adc_k   = 0;
            adc_cnt = 0;
        end
    end

    // Filter model: average of pushed samples
    int psum = 0;
    bit fpend = 1'b0;
    always @(negedge clk) begin
        filt_done = 1'b0;
        if (fpend) begin
            filt_done   = 1'b1;
            filt_result = 12'(psum / NSAMP);
            psum        = 0;
            fpend       = 1'b0;
        end
        if (filt_go) fpend = 1'b1;
    end

    // Monitor
    int         nwr = 0;
    int         nreq = 0;
    int         npush = 0;
    int         acq_run = 0;
    int         acq_bad = 0;
    int         exp_acq = 1;
    logic [2:0]  wch [32];
    logic [11:0] wdat [32];
    always @(negedge clk) begin
        #1;
        if (wr_en) begin
            if (nwr < 32) begin
                wch[nwr]  = wr_chan;
                wdat[nwr] = wr_data;
            end
            nwr++;
        end
        if (conv_req) nreq++;
        if (filt_push) begin
            psum += int'(conv_data);
            npush++;
        end
        if (acq_active) acq_run++;
        else if (acq_run > 0) begin
            if (acq_run != exp_acq) acq_bad++;
            acq_run = 0;
        end
        if (mode == 2'b00 && !fpend) psum = 0;
    end

    task automatic clear_log();
        nwr = 0; nreq = 0; npush = 0; acq_bad = 0;
    endtask

    task automatic go_idle();
        @(negedge clk);
        mode = 2'b00;
        repeat (6) @(negedge clk);
    endtask

    // Vectors: {mask, acq, filt}
    localparam logic [12:0] VEC [5] = '{
        {8'hFE, 4'd0,  1'b0},
        {8'hA5, 4'd3,  1'b0},
        {8'h81, 4'd7,  1'b1},
        {8'h01, 4'd2,  1'b0},
        {8'h5A, 4'd15, 1'b1}
    };

    initial begin
        int n0;
        int exp_n;
        int e_ch [8];
        int e_dat [8];
        int bad;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!conv_req && !wr_en && !acq_active && !filt_go, "R1 outputs idle", int'({conv_req, wr_en, acq_active, filt_go}), 0);
        chk(!irq && alert_flags == 3'b000, "R1 alerts clear", int'({irq, alert_flags}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 mode 00 converts nothing
        cfg_word = 16'h00FE;
        repeat (60) @(negedge clk);
        chk(nreq == 0, "R3 mode 00 no requests", nreq, 0);

        // Table walk in single mode: R2 order, R6 acquisition, R7 filtering
        foreach (VEC[v]) begin
            go_idle();
            clear_log();
            cfg_word   = {8'h00, VEC[v][12:5]};
            acq_cycles = VEC[v][4:1];
            filt_en    = VEC[v][0];
            exp_acq    = int'(VEC[v][4:1]) + 1;
            exp_n = 0;
            for (int b = 7; b >= 1; b--) begin
                if (VEC[v][5 + b]) begin
                    e_ch[exp_n]  = b;
                    e_dat[exp_n] = b * 256 + (VEC[v][0] ? 3 : 0);
                    exp_n++;
                end
            end
            @(negedge clk);
            mode = 2'b01;
            repeat (400) @(negedge clk);
            chk(nwr == exp_n, "R2 write count", nwr, exp_n);
            bad = 0;
            for (int i = 0; i < exp_n && i < nwr; i++) begin
                if (int'(wch[i]) != e_ch[i]) begin
                    bad++;
                    chk(1'b0, "R2 channel order", int'(wch[i]), e_ch[i]);
                end
                if (int'(wdat[i]) != e_dat[i]) begin
                    bad++;
                    chk(1'b0, "R7 written value", int'(wdat[i]), e_dat[i]);
                end
            end
            chk(bad == 0, "R2 sequence contents", bad, 0);
            chk(acq_bad == 0, "R6 acquisition length", acq_bad, 0);
            chk(nreq == exp_n * (VEC[v][0] ? NSAMP : 1), "R7 samples per channel", nreq, exp_n * (VEC[v][0] ? NSAMP : 1));
            if (VEC[v][0])
                chk(npush == exp_n * NSAMP, "R7 filter pushes", npush, exp_n * NSAMP);
        end
        // R3 single mode does not repeat
        n0 = nwr;
        repeat (150) @(negedge clk);
        chk(nwr == n0, "R3 single runs once", nwr, n0);

        // R4 slave repeating
        go_idle();
        clear_log();
        cfg_word = 16'h0080; acq_cycles = 4'd0; filt_en = 1'b0; interval = 2'b01;
        @(negedge clk); mode = 2'b10;
        repeat (200) @(negedge clk);
        chk(nwr >= 3, "R4 slave repeats", nwr, 3);
        // R4 interval 00 single pass
        go_idle();
        clear_log();
        interval = 2'b00;
        @(negedge clk); mode = 2'b10;
        repeat (200) @(negedge clk);
        chk(nwr == 1, "R4 slave interval 00", nwr, 1);

        // R5 master mode
        go_idle();
        clear_log();
        interval = 2'b01; touch = 1'b0;
        @(negedge clk); mode = 2'b11;
        repeat (100) @(negedge clk);
        chk(nwr == 0, "R5 no touch no conversion", nwr, 0);
        touch = 1'b1;
        repeat (150) @(negedge clk);
        chk(nwr >= 2, "R5 repeats while touched", nwr, 2);
        touch = 1'b0;
        repeat (60) @(negedge clk);
        n0 = nwr;
        repeat (150) @(negedge clk);
        chk(nwr == n0, "R5 stops on release", nwr, n0);

        // R10 abort mid-acquisition, then restart from the top
        go_idle();
        clear_log();
        cfg_word = 16'h00FE; acq_cycles = 4'd15; exp_acq = 16;
        @(negedge clk); mode = 2'b01;
        repeat (8) @(negedge clk);
        mode = 2'b00;
        repeat (60) @(negedge clk);
        chk(nwr == 0 && nreq == 0, "R10 abort no write", nwr + nreq, 0);
        @(negedge clk); mode = 2'b01;
        repeat (300) @(negedge clk);
        chk(nwr == 7 && wch[0] == 3'd7, "R10 restart from top", int'(wch[0]), 7);

        // R8 limit alerts; TEMP and AUX violate
        go_idle();
        clear_log();
        cfg_word = 16'h000E; acq_cycles = 4'd0; exp_acq = 1;
        lim_lo = {12'h000, 12'h100, 12'h200};
        lim_hi = {12'h2FF, 12'h300, 12'hFFF};
        @(negedge clk); mode = 2'b01;
        repeat (100) @(negedge clk);
        chk(alert_flags == 3'b101, "R8 alert flags", int'(alert_flags), 5);
        chk(irq == 1'b1, "R8 irq raised", int'(irq), 1);
        // R11 clear
        alert_clr = 1'b1;
        @(negedge clk);
        alert_clr = 1'b0;
        @(negedge clk);
        chk(alert_flags == 3'b000 && !irq, "R11 clear", int'({irq, alert_flags}), 0);
        // R9 suppress TEMP via bit 9
        go_idle();
        cfg_word = 16'h020E;
        @(negedge clk); mode = 2'b01;
        repeat (100) @(negedge clk);
        chk(alert_flags == 3'b100, "R9 TEMP suppressed", int'(alert_flags), 4);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule